// File: doc/BRIEF.md
# Addressed Serial Channel Code Register Bank

This block is the digital receive side of a multi-channel serial DAC. A host sends 12-bit command words over three wires: a data line, a shift clock and a load strobe. The block samples all three wires into its own system clock domain. Each rising edge of the shift clock moves one data bit into a 12-bit shift register, with the most significant bit sent first.

A rising edge of the load strobe applies the word held in the shift register. The top four bits of the word are an address that picks one of up to eight 6-bit channel registers. The lowest six bits are the code written into that register. Two further bits drive a pair of general-purpose option outputs. These two bits are applied on every load, whatever the address holds.

The last stage of the shift register is driven out as serial data, so that several blocks can share one clock and one strobe in a daisy chain. Each channel code is output as a 6-bit digital bus. A code n stands for an analog level of (n+1)/64 of full scale. The conversion to an analog level is done outside this block. A parameter builds either a four-channel or an eight-channel variant.

Top module: `serial_dac_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every channel code, `opt_lo`, `opt_hi` and `ser_dout` are 0.
- R2: Each rising edge of `ser_clk` shifts `ser_din` into bit 0 of the 12-bit shift register and moves the other bits up one place. The first bit sent ends in bit 11, so word bit 11 is sent first and bit 0 is sent last.
- R3: On a rising edge of `ser_load`, the address in word bits 11..8 is read. A value a in the range 1 to `NUM_CH` writes word bits 5..0 (bit 5 most significant) into channel a. Channel a occupies `ch_code[(a-1)*6 +: 6]`. No other channel changes.
- R4: Address 0 writes no channel. Addresses 9 to 15 also write no channel. An address with bit 11 set is a don't-care code, except for 8 (binary 1000).
- R5: With `NUM_CH`=4, addresses 5 to 8 write no channel. With `NUM_CH`=8, address 8 writes channel 8.
- R6: `ser_dout` always equals bit 11 of the shift register. It changes only when a shift takes place.
- R7: Every rising edge of `ser_load` latches word bit 6 into `opt_lo` and word bit 7 into `opt_hi`, with 1 meaning high. This happens for every address, valid or not.
- R8: Shift-clock edges without a load edge change no channel code and no option output.
- R9: Each input passes through `SYNC_STAGES` synchronizer flops and one edge-detect flop. With the default of 2, a shift or a load takes effect at the outputs 3 system clock cycles after the cycle in which the input edge was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial data in, sampled on the shift clock's rising edge |
| ser_clk | input | 1 | Serial shift clock (asynchronous to `clk`) |
| ser_load | input | 1 | Load strobe; its rising edge applies the word |
| ser_dout | output | 1 | Last stage of the shift register, used for chaining |
| opt_lo | output | 1 | Option output driven by word bit 6 |
| opt_hi | output | 1 | Option output driven by word bit 7 |
| ch_code | output | NUM_CH*6 | Channel codes, channel a at bits (a-1)*6 +: 6 |

## Verification
The bench builds two copies of the block from the same serial wires. One copy uses `NUM_CH`=8 and the other uses `NUM_CH`=4. Together they show that address 8 reaches a real register in the wide build. They also show that addresses 5 to 8 fall through harmlessly in the narrow build. Both copies run with the default two-stage synchronizer, which makes the three-cycle latency of R9 the timing that the per-clock model must match. Frames with addresses 0, 9 and 15, and a word shifted through without a load, drive the no-write and chaining paths.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  // Field widths of a command word; they are fixed by the frame format.
  localparam int CODE_W  = 6;
  localparam int ADDR_W  = 4;
  localparam int FRAME_W = ADDR_W + 2 + CODE_W;

  // Field layout of one command word, most significant field first.
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              opt_hi;
    logic              opt_lo;
    logic [CODE_W-1:0] code;
  } frame_t;

  // Returns true when the address field selects the given zero-based channel.
  function automatic logic chan_hit(input logic [ADDR_W-1:0] addr, input int idx);
    return addr == ADDR_W'(idx + 1);
  endfunction

endpackage

// File: rtl/sdb_sync.sv
module sdb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sdb_edge.sv
module sdb_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) last <= '0;
    else     last <= lvl;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_rise
      assign rise[g] = lvl[g] & ~last[g];
    end
  endgenerate

endmodule

// File: rtl/sdb_shifter.sv
module sdb_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         tail
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (shift) sr <= {sr[W-2:0], bit_in};
  end

  assign word = sr;
  assign tail = sr[W-1];

endmodule

// File: rtl/sdb_chan_bank.sv
module sdb_chan_bank import sdb_pkg::*; #(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  frame_t                   fr,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic                     opt_lo,
  output logic                     opt_hi
);

  logic [CODE_W-1:0] regs [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) regs[i] <= '0;
      opt_lo <= 1'b0;
      opt_hi <= 1'b0;
    end else if (load) begin
      for (int i = 0; i < NUM_CH; i++)
        if (chan_hit(fr.addr, i)) regs[i] <= fr.code;
      opt_lo <= fr.opt_lo;
      opt_hi <= fr.opt_hi;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_flat
      assign codes[g*CODE_W +: CODE_W] = regs[g];
    end
  endgenerate

endmodule

// File: rtl/serial_dac_bank.sv
module serial_dac_bank import sdb_pkg::*; #(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_din,
  input  logic                     ser_clk,
  input  logic                     ser_load,
  output logic                     ser_dout,
  output logic                     opt_lo,
  output logic                     opt_hi,
  output logic [NUM_CH*CODE_W-1:0] ch_code
);

  localparam int N_IN = 3;

  logic [N_IN-1:0]    raw_in, sync_in;
  logic [1:0]         pulses;
  logic               shift_pulse, load_pulse;
  logic [FRAME_W-1:0] frame;

  assign raw_in = {ser_load, ser_clk, ser_din};

  sdb_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  sdb_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sync_in[2:1]),
    .rise (pulses)
  );

  assign shift_pulse = pulses[0];
  assign load_pulse  = pulses[1];

  sdb_shifter #(.W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .shift  (shift_pulse),
    .bit_in (sync_in[0]),
    .word   (frame),
    .tail   (ser_dout)
  );

  sdb_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (load_pulse),
    .fr     (frame_t'(frame)),
    .codes  (ch_code),
    .opt_lo (opt_lo),
    .opt_hi (opt_hi)
  );

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker import sdb_pkg::*; #(
  parameter int NUM_CH = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ser_dout,
  input logic                     opt_lo,
  input logic                     opt_hi,
  input logic [NUM_CH*CODE_W-1:0] ch_code,
  input logic                     shift_pulse,
  input logic                     load_pulse,
  input logic [FRAME_W-1:0]       frame
);

  logic [NUM_CH*CODE_W-1:0] prev_code;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk) begin
    if (rst) prev_code <= '0;
    else     prev_code <= ch_code;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign chg[g] = ch_code[g*CODE_W +: CODE_W] != prev_code[g*CODE_W +: CODE_W];

      assert_write_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (load_pulse && frame[FRAME_W-1 -: ADDR_W] == ADDR_W'(g + 1))
          |=> ch_code[g*CODE_W +: CODE_W] == $past(frame[CODE_W-1:0]));
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_code == '0 && !opt_lo && !opt_hi && !ser_dout));

  assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> ser_dout == $past(frame[FRAME_W-2]));

  assert_single_channel_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));

  assert_no_write_R4_R5: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && (frame[FRAME_W-1 -: ADDR_W] == '0 ||
                    frame[FRAME_W-1 -: ADDR_W] > ADDR_W'(NUM_CH)))
      |=> $stable(ch_code));

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_pulse |=> $stable(ser_dout));

  assert_option_latch_R7: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> (opt_hi == $past(frame[CODE_W+1]) && opt_lo == $past(frame[CODE_W])));

  assert_hold_no_load_R8: assert property (@(posedge clk) disable iff (rst)
    !load_pulse |=> ($stable(ch_code) && $stable(opt_lo) && $stable(opt_hi)));

endmodule

bind serial_dac_bank sdb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ser_dout    (ser_dout),
  .opt_lo      (opt_lo),
  .opt_hi      (opt_hi),
  .ch_code     (ch_code),
  .shift_pulse (shift_pulse),
  .load_pulse  (load_pulse),
  .frame       (frame)
);

// File: tb/sim_serial_dac_bank.sv
module sim_serial_dac_bank;

  logic clk = 0, rst = 1, din = 0, sclk = 0, ld = 0;
  always #10 clk = ~clk;

  logic dout0, dout1, olo0, olo1, ohi0, ohi1;
  logic [47:0] ch0;
  logic [23:0] ch1;

  serial_dac_bank #(.NUM_CH(8)) u0 (
    .clk(clk), .rst(rst), .ser_din(din), .ser_clk(sclk), .ser_load(ld),
    .ser_dout(dout0), .opt_lo(olo0), .opt_hi(ohi0), .ch_code(ch0));

  serial_dac_bank #(.NUM_CH(4)) u1 (
    .clk(clk), .rst(rst), .ser_din(din), .ser_clk(sclk), .ser_load(ld),
    .ser_dout(dout1), .opt_lo(olo1), .opt_hi(ohi1), .ch_code(ch1));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  // Behavioural reference: input histories as queues, state as integers.
  bit q_d[$], q_c[$], q_l[$];
  int m_sr, m_lo, m_hi;
  int m_ch[8];

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q_d = {0, 0, 0}; q_c = {0, 0, 0}; q_l = {0, 0, 0};
      m_sr = 0; m_lo = 0; m_hi = 0;
      foreach (m_ch[i]) m_ch[i] = 0;
    end else begin
      // R9: an input sampled two edges back is seen as a fresh level now.
      if (q_l[1] && !q_l[2]) begin
        int a;
        a = (m_sr >> 8) & 15;
        if (a >= 1 && a <= 8) m_ch[a-1] = m_sr & 63;
        m_lo = (m_sr >> 6) & 1;
        m_hi = (m_sr >> 7) & 1;
      end
      if (q_c[1] && !q_c[2]) m_sr = ((m_sr << 1) | int'(q_d[1])) & 12'hfff;
      q_d.push_front(din); void'(q_d.pop_back());
      q_c.push_front(sclk); void'(q_c.pop_back());
      q_l.push_front(ld); void'(q_l.pop_back());
    end
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired: actual=%0d cycles expected<=100000", cyc);
      finish_up();
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R6 dout u0", dout0, (m_sr >> 11) & 1);
      chk("R6 dout u1", dout1, (m_sr >> 11) & 1);
      chk("R7 opts u0", {ohi0, olo0}, {m_hi[0], m_lo[0]});
      chk("R7 opts u1", {ohi1, olo1}, {m_hi[0], m_lo[0]});
      for (int i = 0; i < 8; i++) begin
        chk("R3 ch u0", (ch0 >> (i*6)) & 6'h3f, m_ch[i]);
        if (i < 4) chk("R5 ch u1", (ch1 >> (i*6)) & 6'h3f, m_ch[i]);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [11:0] w);
    for (int b = 11; b >= 0; b--) begin
      din = w[b];
      wait_cyc(3); sclk = 1;
      wait_cyc(3); sclk = 0;
      wait_cyc(3);
    end
  endtask

  task automatic strobe();
    ld = 1; wait_cyc(3); ld = 0; wait_cyc(5);
  endtask

  function automatic logic [11:0] mk(input int a, input bit hi, input bit lo, input int code);
    return {a[3:0], hi, lo, code[5:0]};
  endfunction

  function automatic logic [5:0] c0(input int ch);
    return ch0[(ch-1)*6 +: 6];
  endfunction

  function automatic logic [5:0] c1(input int ch);
    return ch1[(ch-1)*6 +: 6];
  endfunction

  initial begin
    wait_cyc(5);
    chk("R1 reset codes u0", ch0, 0);
    chk("R1 reset codes u1", ch1, 0);
    chk("R1 reset opts", {ohi0, olo0, dout0}, 0);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;
    chk("R1 after release", {ch0, ohi0, olo0, dout0}, 0);

    // R2 R3: an asymmetric code exposes bit order.
    shift_word(mk(1, 0, 1, 6'h2a)); strobe();
    chk("R2 R3 ch1 u0", c0(1), 6'h2a);
    chk("R3 ch1 u1", c1(1), 6'h2a);
    chk("R7 opt lo only", {ohi0, olo0}, 2'b01);

    shift_word(mk(8, 1, 0, 6'h3f)); strobe();
    chk("R5 ch8 u0", c0(8), 6'h3f);
    chk("R5 narrow unchanged", ch1, 24'h00002a);
    chk("R7 opt hi only", {ohi1, olo1}, 2'b10);

    shift_word(mk(5, 0, 0, 6'h15)); strobe();
    chk("R5 ch5 u0", c0(5), 6'h15);
    chk("R5 narrow ignores 5", ch1, 24'h00002a);

    // R4: don't-care addresses write nothing but options still latch (R7).
    shift_word(mk(0, 1, 1, 6'h11)); strobe();
    chk("R4 addr0", ch0, {6'h3f, 6'h0, 6'h0, 6'h15, 24'h00002a});
    chk("R7 opts on addr0", {ohi0, olo0}, 2'b11);
    shift_word(mk(9, 0, 1, 6'h07)); strobe();
    chk("R4 addr9", ch0, {6'h3f, 6'h0, 6'h0, 6'h15, 24'h00002a});
    shift_word(mk(15, 1, 0, 6'h3c)); strobe();
    chk("R4 addr15", ch0, {6'h3f, 6'h0, 6'h0, 6'h15, 24'h00002a});
    chk("R7 opts on addr15", {ohi0, olo0}, 2'b10);

    shift_word(mk(3, 0, 0, 6'h3f)); strobe();
    shift_word(mk(4, 0, 0, 6'h00)); strobe();
    chk("R3 ch3", c0(3), 6'h3f);
    chk("R3 ch4 zero", c1(4), 6'h00);
    chk("R3 ch1 kept", c0(1), 6'h2a);

    // R6 R8: shift a word with no load; outputs hold, dout shows its MSB.
    shift_word(mk(2, 1, 1, 6'h0f));
    chk("R8 codes hold", ch0, {6'h3f, 6'h0, 6'h0, 6'h15, 6'h00, 6'h3f, 6'h0, 6'h2a});
    chk("R8 opts hold", {ohi0, olo0}, 2'b00);
    chk("R6 dout msb", dout0, 1'b0);
    shift_word(mk(10, 0, 0, 6'h01));
    chk("R6 dout next msb", dout1, 1'b1);
    shift_word(mk(2, 1, 1, 6'h0f)); strobe();
    chk("R3 ch2 after chain", c0(2), 6'h0f);
    chk("R7 opts after chain", {ohi1, olo1}, 2'b11);

    wait_cyc(10);
    finish_up();
  end

endmodule